// File: doc/BRIEF.md
# System Clock Divider Controller

This block runs on a fast 64 MHz reference clock and produces a single-cycle clock enable that defines a slower system clock whose ratio to the reference is a power of two. Software writes a 3-bit divide code, and the block holds it as the requested ratio. A separate read-only status field shows the ratio that is actually driving the enable. Downstream logic gates its work with the enable, or feeds it to a clock gate.

A free-running 7-bit phase counter decides when a new ratio starts. A requested ratio is applied only on the edge where that counter wraps to zero. Every divided phase is therefore a whole number of fast cycles, and no short pulse can occur. Two kinds of write are changed before they are stored. When the radio is active, very slow codes are replaced by a safer rate. A full-rate code written while the external oscillator path is selected asks the clock tree to return to the internal oscillator, and to restart that oscillator if it is stopped.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: A status code k (0..6) makes clk_en pulse exactly once every 2^k fast cycles. The pulses fall on the cycles where the low k bits of the phase counter are zero. Cycle 0 is the first cycle after reset release. Code 0 keeps clk_en high all the time.
- R2: While radio_en is 1, a write of 100, 101 or 110 is stored as 010 (divide by 4, 16 MHz). Other codes are stored unchanged.
- R3: A write of the reserved code 111 is ignored. sel_q and div_status keep their values.
- R4: div_status changes only on the edge where the phase counter goes from 127 to 0. That happens after 128·n fast cycles from reset release. On that edge it takes the value sel_q held just before the edge, and the new enable pattern starts on the same edge.
- R5: A write reaches div_status within 1 to 128 fast cycles. If several writes arrive before the next counter wrap, only the last one takes effect.
- R6: When wr_en is 1, wr_sel is 000 and ext_src_req is 1, ret_int_req is 1 on the next cycle. If int_osc_off is also 1, osc_restart_req is 1 on that cycle too. Otherwise osc_restart_req is 0.
- R7: Synchronous reset (rst = 1) sets sel_q and div_status to 001, restarts the phase counter at 0, sets clk_en to 1 and clears both request outputs.
- R8: A write of 000 with ext_src_req at 0 is stored like any other code and raises no request. Any cycle without such a write leaves ret_int_req and osc_restart_req at 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the divide code |
| wr_sel | input | 3 | Divide code written (k = divide by 2^k, 111 reserved) |
| radio_en | input | 1 | Radio active; caps the slow codes to 010 |
| ext_src_req | input | 1 | 1 = external oscillator path is requested |
| int_osc_off | input | 1 | 1 = internal oscillator is currently stopped |
| clk_en | output | 1 | Registered single-cycle enable of the divided clock |
| sel_q | output | 3 | Requested divide code as stored |
| div_status | output | 3 | Divide code currently applied to clk_en |
| ret_int_req | output | 1 | One-cycle request to switch back to the internal oscillator |
| osc_restart_req | output | 1 | One-cycle request to restart the internal oscillator |

## Verification
The bench writes codes in several phase positions. These include the last cycle before a counter wrap and the wrap edge itself. A design that applied a ratio early, or that compared against the wrong counter value, would move div_status off a multiple of 128 cycles, or would lag more than 128 cycles. Back-to-back writes before a wrap check that a latched first value does not win. Radio-capped codes, the reserved code and full-rate writes are each tried with the external and oscillator-stopped flags in every combination. Missing rewrites or stray requests show up at sel_q and at the request pins. Counting clk_en pulses over a full counter period for every code catches an off-by-one mask or a misaligned pulse.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t CODE_FULL    = 3'b000;
  localparam sel_t CODE_RESET   = 3'b001;
  localparam sel_t CODE_RADIO   = 3'b010;
  localparam sel_t CODE_SLOW_LO = 3'b100;
  localparam sel_t CODE_SLOW_HI = 3'b110;
  localparam sel_t CODE_RSV     = 3'b111;

  // Store-time translation of a written code.
  function automatic sel_t sel_filter(input sel_t code, input logic radio);
    if (radio && code >= CODE_SLOW_LO && code <= CODE_SLOW_HI)
      return CODE_RADIO;
    return code;
  endfunction
endpackage

// File: rtl/sysdiv_sel_reg.sv
module sysdiv_sel_reg
  import sysdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  sel_t wr_sel,
  input  logic radio_en,
  input  logic ext_src_req,
  input  logic int_osc_off,
  output sel_t sel_q,
  output logic ret_int_req,
  output logic osc_restart_req
);
  logic accept;
  logic full_on_ext;
  sel_t stored;

  always_comb begin
    accept      = wr_en && (wr_sel != CODE_RSV);
    full_on_ext = wr_en && (wr_sel == CODE_FULL) && ext_src_req;
    stored      = sel_filter(wr_sel, radio_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q           <= CODE_RESET;
      ret_int_req     <= 1'b0;
      osc_restart_req <= 1'b0;
    end else begin
      if (accept) sel_q <= stored;
      ret_int_req     <= full_on_ext;
      osc_restart_req <= full_on_ext && int_osc_off;
    end
  end
endmodule

// File: rtl/sysdiv_phase_ctr.sv
module sysdiv_phase_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  always_comb begin
    cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    wrap    = &cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sysdiv_en_gen.sv
module sysdiv_en_gen
  import sysdiv_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             wrap,
  input  sel_t             sel_q,
  output sel_t             div_status,
  output logic             clk_en
);
  sel_t             status_nxt;
  logic [CNT_W-1:0] mask_nxt;

  always_comb begin
    status_nxt = wrap ? sel_q : div_status;
    for (int i = 0; i < CNT_W; i++)
      mask_nxt[i] = (i < int'(status_nxt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_status <= CODE_RESET;
      clk_en     <= 1'b1;
    end else begin
      div_status <= status_nxt;
      clk_en     <= ((cnt_nxt & mask_nxt) == '0);
    end
  end
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic       radio_en,
  input  logic       ext_src_req,
  input  logic       int_osc_off,
  output logic       clk_en,
  output logic [2:0] sel_q,
  output logic [2:0] div_status,
  output logic       ret_int_req,
  output logic       osc_restart_req
);
  logic [CNT_W-1:0] ctr_q;
  logic [CNT_W-1:0] ctr_nxt;
  logic             ctr_wrap;

  sysdiv_sel_reg u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .radio_en(radio_en), .ext_src_req(ext_src_req), .int_osc_off(int_osc_off),
    .sel_q(sel_q), .ret_int_req(ret_int_req), .osc_restart_req(osc_restart_req)
  );

  sysdiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .cnt_q(ctr_q), .cnt_nxt(ctr_nxt), .wrap(ctr_wrap)
  );

  sysdiv_en_gen #(.CNT_W(CNT_W)) u_en (
    .clk(clk), .rst(rst), .cnt_nxt(ctr_nxt), .wrap(ctr_wrap),
    .sel_q(sel_q), .div_status(div_status), .clk_en(clk_en)
  );

  logic unused_ctr;
  assign unused_ctr = ^ctr_q;
endmodule

// File: rtl/sysclk_div_ctrl_chk.sv
module sysclk_div_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       radio_en,
  input logic       ext_src_req,
  input logic       int_osc_off,
  input logic       clk_en,
  input logic [2:0] sel_q,
  input logic [2:0] div_status,
  input logic       ret_int_req,
  input logic       osc_restart_req,
  input logic       wrap
);
  AST_FULL_RATE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (div_status == 3'b000) |-> clk_en); // R1
  AST_RADIO_CAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && radio_en && wr_sel >= 3'b100 && wr_sel <= 3'b110) |=> (sel_q == 3'b010)); // R2
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'b111) |=> $stable(sel_q)); // R3
  AST_STATUS_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_status) |-> $past(wrap)); // R4
  AST_STATUS_TAKES_SEL: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (div_status == $past(sel_q))); // R4
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    div_status != 3'b111); // R4
  AST_RETURN_REQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'b000 && ext_src_req) |=> ret_int_req); // R6
  AST_RESTART_REQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'b000 && ext_src_req) |=> (osc_restart_req == $past(int_osc_off))); // R6
  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == 3'b000 && ext_src_req) |=> !(ret_int_req || osc_restart_req)); // R8
endmodule

bind sysclk_div_ctrl sysclk_div_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .radio_en(radio_en),
  .ext_src_req(ext_src_req), .int_osc_off(int_osc_off), .clk_en(clk_en),
  .sel_q(sel_q), .div_status(div_status), .ret_int_req(ret_int_req),
  .osc_restart_req(osc_restart_req), .wrap(ctr_wrap)
);

// File: tb/sysclk_div_ctrl_tb_top.sv
module sysclk_div_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'b000;
  logic       radio_en = 1'b0;
  logic       ext_src_req = 1'b0;
  logic       int_osc_off = 1'b0;
  logic       clk_en;
  logic [2:0] sel_q;
  logic [2:0] div_status;
  logic       ret_int_req;
  logic       osc_restart_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysclk_div_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .radio_en(radio_en),
    .ext_src_req(ext_src_req), .int_osc_off(int_osc_off), .clk_en(clk_en),
    .sel_q(sel_q), .div_status(div_status), .ret_int_req(ret_int_req),
    .osc_restart_req(osc_restart_req)
  );

  // Spec model built from the requirements.
  logic [6:0] m_cnt;
  logic [2:0] m_sel, m_stat, st_n;
  logic       m_en, m_ret, m_rs;

  function automatic logic [6:0] mask_of(input logic [2:0] k);
    return 7'((8'd1 << k) - 8'd1);
  endfunction

  function automatic logic [2:0] stored_code(input logic radio, input logic [2:0] c);
    if (radio && c >= 3'b100 && c <= 3'b110) return 3'b010;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_sel <= 3'b001; m_stat <= 3'b001;
      m_en <= 1'b1; m_ret <= 1'b0; m_rs <= 1'b0;
    end else begin
      st_n = (m_cnt == 7'd127) ? m_sel : m_stat;
      m_en   <= (((m_cnt + 7'd1) & mask_of(st_n)) == 7'd0);
      m_stat <= st_n;
      m_cnt  <= m_cnt + 7'd1;
      if (wr_en && wr_sel != 3'b111) m_sel <= stored_code(radio_en, wr_sel);
      m_ret <= wr_en && wr_sel == 3'b000 && ext_src_req;
      m_rs  <= wr_en && wr_sel == 3'b000 && ext_src_req && int_osc_off;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 clk_en", clk_en, m_en);
    chk("R4 div_status", div_status, m_stat);
    chk("R2 R3 R5 sel_q", sel_q, m_sel);
    chk("R6 R8 ret_int_req", ret_int_req, m_ret);
    chk("R6 R8 osc_restart_req", osc_restart_req, m_rs);
  endtask

  task automatic tick(input logic w, input logic [2:0] s);
    wr_en = w; wr_sel = s;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_until_wrap();
    while (m_cnt != 7'd127) tick(1'b0, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lag;
    int pulses;
    logic [2:0] keep;
    void'($urandom(32'd5177));
    repeat (3) @(negedge clk);
    // R7 reset values
    chk("R7 sel_q", sel_q, 1); chk("R7 div_status", div_status, 1);
    chk("R7 clk_en", clk_en, 1); chk("R7 ret_int_req", ret_int_req, 0);
    chk("R7 osc_restart_req", osc_restart_req, 0);
    rst = 1'b0;
    tick(1'b0, 3'b000);

    // R1: pulse count per full counter period for each code
    for (int k = 0; k < 7; k++) begin
      tick(1'b1, 3'(k));
      idle_until_wrap();
      tick(1'b0, 3'b000);
      chk("R1 status reached", div_status, k);
      pulses = 0;
      for (int i = 0; i < 128; i++) begin
        if (clk_en) pulses++;
        tick(1'b0, 3'b000);
      end
      chk("R1 pulse count", pulses, 128 >> k);
    end

    // R2 radio cap
    radio_en = 1'b1;
    tick(1'b1, 3'b101);
    chk("R2 capped", sel_q, 2);
    tick(1'b1, 3'b011);
    chk("R2 uncapped", sel_q, 3);
    radio_en = 1'b0;

    // R3 reserved code ignored
    keep = sel_q;
    tick(1'b1, 3'b111);
    chk("R3 sel kept", sel_q, keep);
    idle_until_wrap();
    tick(1'b0, 3'b000);
    chk("R3 status kept", div_status, keep);

    // R5 lag bound and latest write wins; write on the wrap cycle itself
    idle_until_wrap();
    tick(1'b1, 3'b100);
    lag = 1;
    while (div_status != 3'b100 && lag < 200) begin tick(1'b0, 3'b000); lag++; end
    chk("R5 lag on wrap edge", lag, 129);
    tick(1'b1, 3'b010);
    tick(1'b1, 3'b110);
    lag = 1;
    while (div_status == 3'b100 && lag < 200) begin tick(1'b0, 3'b000); lag++; end
    chk("R5 lag bounded", (lag <= 128) ? 1 : 0, 1);
    chk("R5 latest wins", div_status, 6);

    // R6 / R8 requests
    ext_src_req = 1'b1; int_osc_off = 1'b1;
    tick(1'b1, 3'b000);
    chk("R6 ret", ret_int_req, 1); chk("R6 restart", osc_restart_req, 1);
    int_osc_off = 1'b0;
    tick(1'b1, 3'b000);
    chk("R6 ret running", ret_int_req, 1); chk("R6 no restart", osc_restart_req, 0);
    ext_src_req = 1'b0; int_osc_off = 1'b1;
    tick(1'b1, 3'b000);
    chk("R8 no ret", ret_int_req, 0); chk("R8 stored", sel_q, 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      radio_en    = ($urandom % 4) == 0;
      ext_src_req = ($urandom % 2) == 0;
      int_osc_off = ($urandom % 2) == 0;
      if (($urandom % 16) == 0) tick(1'b1, 3'($urandom % 8));
      else tick(1'b0, 3'($urandom % 8));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule